// File: doc/BRIEF.md
# Duty-Cycle Fine-Resolution Interpolator

This block lets a 16-bit DAC core reach 18-bit resolution. The block keeps an 18-bit code. The upper 16 bits form a coarse value C and the two lowest bits form a fine value. The block then drives a 16-bit word into the core. That word toggles between C and C+1, and the share of time spent on C+1 follows the fine value. An analog filter after the core averages the two levels, so the mean settles at the 18-bit level.

Time is divided into interpolation periods of four sub-slots each. A clock divider sets the length of one sub-slot through a parameter, so the period rate can be tuned to the required update rate. The default gives a 10 kHz period rate from a 200 MHz clock. New codes arrive on a single-cycle load strobe. A new code is held back until the current period ends, so each period works from one consistent code.

Top module: `dither_interp_top`

## Requirements
- R1: The coarse value C is code bits [17:2] and the fine value F is code bits [1:0]; for example, code 4093 gives C = 1023 with F = 1, and code 4096 gives C = 1024 with F = 0.
- R2: The output is always either C or the incremented coarse value of the code currently in use.
- R3: Within every period of four sub-slots, the output shows the incremented value during the first F sub-slots and shows C during the remaining ones. F = 0, 1, 2, 3 therefore gives 0%, 25%, 50% and 75% time at the higher code.
- R4: When C equals 0xFFFF, the incremented value saturates at 0xFFFF and does not wrap to zero.
- R5: A code loaded in the middle of a period takes effect at the start of the next period. If several loads arrive before that boundary, including a load in the boundary cycle itself, the last one is used.
- R6: While reset is asserted, the sub-slot position is zero and the output equals the reset coarse value RST_COARSE. The fine value of the reset code is zero.
- R7: A sub-slot lasts exactly SLOT_DIV clock cycles, so a period lasts 4*SLOT_DIV cycles. Counting from reset release, periods start at cycle multiples of 4*SLOT_DIV.
- R8: With F = 0, the output stays constant at C for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | 18 | Code to be loaded |
| load_i | input | 1 | Single-cycle strobe that captures code_i |
| dac_code_o | output | 16 | Word driven into the DAC core |

## Verification
The hardest situation to reach is a load that coincides with the period boundary, or several loads inside one period. Only the value present at the boundary may be used, and a mistake here shows up in the output only one period later. The stimulus sends two codes a few cycles apart and also sends loads at arbitrary offsets, so some of them land exactly on a boundary edge. A cycle-accurate model advances on the bench's own edge count and checks every cycle. The same stimulus also drives C = 0xFFFF with nonzero fine values, which exercises the saturation path.

// File: rtl/dither_interp_pkg.sv
package dither_interp_pkg;
  localparam int unsigned CODE_W   = 18;
  localparam int unsigned FINE_W   = 2;
  localparam int unsigned COARSE_W = CODE_W - FINE_W;
  localparam int unsigned SLOTS    = 1 << FINE_W;

  typedef logic [CODE_W-1:0]   code_t;
  typedef logic [COARSE_W-1:0] coarse_t;
  typedef logic [FINE_W-1:0]   fine_t;

  function automatic coarse_t sat_inc(coarse_t c);
    return (&c) ? c : c + coarse_t'(1);
  endfunction
endpackage

// File: rtl/slot_tick_gen.sv
module slot_tick_gen #(
  parameter int unsigned SLOT_DIV = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (SLOT_DIV > 2) ? $clog2(SLOT_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + CNT_W'(1);
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/slot_seq.sv
module slot_seq
  import dither_interp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  output fine_t slot_o,
  output logic  wrap_o
);
  fine_t slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     slot_q <= '0;
    else if (tick_i) slot_q <= slot_q + fine_t'(1);
  end

  // last sub-slot ending: next edge starts a new period
  assign wrap_o = tick_i & (&slot_q);
  assign slot_o = slot_q;
endmodule

// File: rtl/code_hold.sv
module code_hold
  import dither_interp_pkg::*;
#(
  parameter coarse_t RST_COARSE = '0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t code_i,
  input  logic  load_i,
  input  logic  wrap_i,
  output code_t act_o
);
  localparam code_t RST_CODE = {RST_COARSE, {FINE_W{1'b0}}};

  code_t pend_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= RST_CODE;
      act_q  <= RST_CODE;
    end else begin
      if (load_i) pend_q <= code_i;
      if (wrap_i) act_q  <= load_i ? code_i : pend_q;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/dither_interp_top.sv
module dither_interp_top
  import dither_interp_pkg::*;
#(
  parameter int unsigned SLOT_DIV   = 5000,
  parameter coarse_t     RST_COARSE = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CODE_W-1:0]   code_i,
  input  logic                load_i,
  output logic [COARSE_W-1:0] dac_code_o
);
  logic    tick, wrap;
  fine_t   slot;
  code_t   act;
  coarse_t coarse;
  fine_t   fine;

  slot_tick_gen #(.SLOT_DIV(SLOT_DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  slot_seq i_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .slot_o(slot),
    .wrap_o(wrap)
  );

  code_hold #(.RST_COARSE(RST_COARSE)) i_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(code_i),
    .load_i(load_i),
    .wrap_i(wrap),
    .act_o (act)
  );

  assign coarse     = act[CODE_W-1:FINE_W];
  assign fine       = act[FINE_W-1:0];
  assign dac_code_o = (slot < fine) ? sat_inc(coarse) : coarse;
endmodule

// File: rtl/dither_interp_chk.sv
module dither_interp_chk
  import dither_interp_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input coarse_t dac_code_o,
  input code_t   act,
  input fine_t   slot,
  input logic    tick,
  input logic    wrap
);
  coarse_t c;
  fine_t   f;
  assign c = act[CODE_W-1:FINE_W];
  assign f = act[FINE_W-1:0];

  a_r2_adjacent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_code_o == c) || (dac_code_o == c + coarse_t'(1)));

  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&c) |-> (&dac_code_o));

  a_r8_flat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f == '0) |-> (dac_code_o == c));

  a_r5_hold_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(act));

  a_r7_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(slot));

  a_r3_first_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot == '0 && !(&c) && f != '0) |-> (dac_code_o != c));
endmodule

bind dither_interp_top dither_interp_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dac_code_o(dac_code_o),
  .act       (act),
  .slot      (slot),
  .tick      (tick),
  .wrap      (wrap)
);

// File: tb/test_dither_interp_top.sv
`timescale 1ns/1ps
module test_dither_interp_top;
  localparam int unsigned D   = 3;
  localparam int unsigned PER = 4 * D;
  localparam logic [15:0] RC  = 16'h8000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] code_i = '0;
  logic        load_i = 1'b0;
  logic [15:0] dac_code_o;

  int n_chk = 0, n_bad = 0;

  dither_interp_top #(.SLOT_DIV(D), .RST_COARSE(RC)) i_dither_interp_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code_i),
    .load_i(load_i), .dac_code_o(dac_code_o)
  );

  always #2 clk_i = ~clk_i;

  logic [17:0] q[$];
  logic [17:0] pend_m = {RC, 2'b00};
  logic [17:0] act_m  = {RC, 2'b00};
  int          e = 0;
  int          hi_cnt = 0;
  bit          done = 0;

  function automatic logic [15:0] inc_sat(logic [15:0] c);
    return (c == 16'hFFFF) ? c : c + 16'd1;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, act, exp, e);
    end
  endtask

  task automatic send(logic [17:0] c);
    @(negedge clk_i);
    code_i = c; load_i = 1'b1; q.push_back(c);
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // monitor: cycle-accurate reference driven by own edge count
  always @(posedge clk_i) begin
    if (rst_ni && !done) begin
      logic [15:0] c, hi, exp;
      logic [1:0]  f;
      int          slot;
      #1;
      e++;
      while (q.size() > 0) pend_m = q.pop_front();
      if (e % PER == 0) begin
        c = act_m[17:2]; f = act_m[1:0];
        if (c != 16'hFFFF) check("R3 duty count", 16'(hi_cnt), 16'(f * D));
        act_m  = pend_m;
        hi_cnt = 0;
      end
      c    = act_m[17:2];
      f    = act_m[1:0];
      hi   = inc_sat(c);
      slot = (e / D) % 4;
      exp  = (slot < int'(f)) ? hi : c;
      if (dac_code_o == c + 16'd1) hi_cnt++;
      check("R2 adjacent", 16'((dac_code_o == c) || (dac_code_o == hi)), 16'd1);
      if (pend_m != act_m)     check("R5 deferred load", dac_code_o, exp);
      else if (c == 16'hFFFF)  check("R4 saturate", dac_code_o, exp);
      else if (f == 2'b00)     check("R8 flat", dac_code_o, exp);
      else if (slot == 0)      check("R7 slot timing", dac_code_o, exp);
      else                     check("R1 split", dac_code_o, exp);
    end
  end

  initial begin
    fork
      begin
        idle(3);
        check("R6 reset out", dac_code_o, RC);
        rst_ni = 1'b1;
        idle(7);
        send(18'd4093);            // C=1023 F=1
        idle(25);
        send(18'd4096);            // C=1024 F=0
        idle(20);
        send(18'h3FFFD);           // C=FFFF F=1
        idle(29);
        send(18'h3FFFF);           // C=FFFF F=3
        idle(23);
        send(18'h12346);           // F=2, overridden
        idle(2);
        send(18'h0ABCF);           // F=3 wins
        idle(31);
        for (int k = 0; k < 12; k++) begin
          send(18'(k * 18'h05A5B + 18'h00777));
          idle(k + 5);
        end
        send(18'h00002);
        idle(40);
      end
      begin
        idle(20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule